// File: doc/BRIEF.md
# Macro-Fusion Decode Group Former

This block sits between a queue of pre-decoded instruction descriptors and a uop queue. In each clock cycle it looks at the first few descriptors at the head of the input queue and builds one decode group. Where a flag-setting ALU operation is directly followed by a conditional branch, it merges the two into a single fused uop. The finished group is presented to the downstream queue with a valid/ready handshake.

The input queue presents a window of up to five descriptors together with a count of how many are present. The block answers in the same cycle with the number it takes. A descriptor that is not taken stays at the head of the queue and is seen again in the next cycle.

Two mode inputs choose the behaviour. The first picks between a policy that allows one fusion per cycle and a policy that allows two. The second picks which operand kinds stop an ALU operation from fusing.

Top module: `fgf_group_former`

## Requirements
- R1: A fusable ALU descriptor that is directly followed by a branch descriptor, with both in the visible window, leaves the block as one slot. That slot has its fused flag set, carries the ALU tag in the first-tag field and the branch tag in the second-tag field. Descriptor layout: tag in bits [7:0], immediate flag in bit 8, memory flag in bit 9, class in bits [11:10]. The class codes are 0 for other, 1 for ALU and 2 for branch.
- R2: With post_rules at 0, an ALU descriptor fuses unless it has both a memory and an immediate operand. With post_rules at 1, an ALU descriptor with a memory operand never fuses, and the immediate flag has no effect.
- R3: With two_fuse_mode at 1, a group holds at most two fused slots. The group closes right after the second fusion, even when more descriptors are visible.
- R4: With two_fuse_mode at 0, a group holds at most one fused slot. A later pair that could fuse in the same group is emitted as two separate unfused slots.
- R5: With two_fuse_mode at 0, a group holds at most four slots. If the fourth slot would hold a fusable ALU descriptor that is not fused in this cycle, the group is cut to three slots and that descriptor is left untaken.
- R6: With two_fuse_mode at 1, a group holds up to five slots. A fusable ALU descriptor whose following descriptor is not visible is emitted unfused.
- R7: in_take equals the number of descriptors placed in the group. It never exceeds in_avail or five.
- R8: While out_valid is high and out_ready is low, every output holds its value and in_take is 0.
- R9: out_uops gives the number of valid slots and out_fusions gives the number of fused slots of the presented group.
- R10: After reset, out_valid is low.
- R11: Other-class descriptors, and branches that do not follow a fusable ALU descriptor, are emitted one per slot. Slots appear in program order and fill from slot 0 upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| two_fuse_mode | input | 1 | 1: two fusions per group, 0: one fusion per group |
| post_rules | input | 1 | Selects the operand rules for fusability |
| in_desc | input | 60 | Window of five descriptors; entry i in bits [12i+11:12i] |
| in_avail | input | 3 | Number of valid window entries |
| in_take | output | 3 | Number of descriptors consumed at this clock edge |
| out_valid | output | 1 | A group is presented |
| out_ready | input | 1 | The downstream queue accepts the group |
| out_slot_vld | output | 5 | Valid flag for each slot |
| out_fused | output | 5 | Fused flag for each slot |
| out_tag_first | output | 40 | Tag of the first (or only) descriptor of each slot |
| out_tag_second | output | 40 | Branch tag of each fused slot, 0 otherwise |
| out_uops | output | 3 | Number of uops in the group |
| out_fusions | output | 2 | Number of fusions in the group |

## Verification
The bench builds the block with its default parameters: a five-entry window, five slots in two-fusion mode and four in one-fusion mode. With these values a single window is wide enough to show the following cases:
- two fusions in one window, and the early close that follows the second;
- the cut to three slots when a fusable descriptor falls on the fourth slot;
- a trailing fusable descriptor whose branch is just outside the window.

Short directed streams are sent in each mode and under both operand rules. One stream is repeated under a stall pattern on out_ready.

// File: rtl/fgf_pkg.sv
// Package: shared descriptor type and encodings for the group former.
// Assumes every descriptor is packed as {class, memory, immediate, tag}.
package fgf_pkg;
    parameter int TAG_W  = 8;
    parameter int DESC_W = TAG_W + 4;

    typedef enum logic [1:0] {
        CLS_OTHER  = 2'd0,
        CLS_ALU    = 2'd1,
        CLS_BRANCH = 2'd2
    } cls_e;

    typedef struct packed {
        cls_e             cls;
        logic             mem;
        logic             imm;
        logic [TAG_W-1:0] tag;
    } desc_t;
endpackage

// File: rtl/fgf_fuse_detect.sv
// Module: marks, for each window position, whether the descriptor is a fusable
// ALU op and whether it forms a complete fusable pair with its visible successor.
// Assumes the window entries at and above avail are don't-care.
module fgf_fuse_detect
    import fgf_pkg::*;
#(
    parameter int WIN   = 5,
    parameter int CNT_W = $clog2(WIN + 1)
) (
    input  desc_t            desc [WIN],
    input  logic [CNT_W-1:0] avail,
    input  logic             post_rules,
    output logic [WIN-1:0]   cand,
    output logic [WIN-1:0]   pair
);
    for (genvar i = 0; i < WIN; i++) begin : g_pos
        // Fusability of this position under the selected operand rules
        assign cand[i] = (desc[i].cls == CLS_ALU) &&
                         (post_rules ? !desc[i].mem : !(desc[i].mem && desc[i].imm));
        if (i < WIN - 1) begin : g_pair
            // A pair needs the successor visible and of branch class
            assign pair[i] = cand[i] && (avail > CNT_W'(i + 1)) &&
                             (desc[i+1].cls == CLS_BRANCH);
        end else begin : g_last
            // The last position never sees its successor
            assign pair[i] = 1'b0;
        end
    end
endmodule

// File: rtl/fgf_group_walker.sv
// Module: walks the window in program order and assigns descriptors to output
// slots. It applies the fusion limit, the group width and the hold-back rule.
// Assumes cand/pair come from fgf_fuse_detect for the same window.
module fgf_group_walker
    import fgf_pkg::*;
#(
    parameter int WIN       = 5,
    parameter int WIDTH_ONE = 4,
    parameter int CNT_W     = $clog2(WIN + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  desc_t                desc [WIN],
    input  logic [CNT_W-1:0]     avail,
    input  logic [WIN-1:0]       cand,
    input  logic [WIN-1:0]       pair,
    input  logic                 two_fuse,
    output logic [WIN-1:0]       slot_vld,
    output logic [WIN-1:0]       slot_fused,
    output logic [WIN*TAG_W-1:0] slot_t0,
    output logic [WIN*TAG_W-1:0] slot_t1,
    output logic [CNT_W-1:0]     consumed,
    output logic [CNT_W-1:0]     n_uops,
    output logic [1:0]           n_fus
);
    localparam int FUSE_TWO = 2;
    localparam int FUSE_ONE = 1;

    // Sequential placement of window entries into slots, one step per position
    always_comb begin
        int p;
        int used;
        int fus;
        int width;
        int limit;
        logic stop;
        slot_vld   = '0;
        slot_fused = '0;
        slot_t0    = '0;
        slot_t1    = '0;
        p     = 0;
        used  = 0;
        fus   = 0;
        stop  = 1'b0;
        width = two_fuse ? WIN : WIDTH_ONE;
        limit = two_fuse ? FUSE_TWO : FUSE_ONE;
        for (int k = 0; k < WIN; k++) begin
            if (!stop && p < int'(avail) && used < width) begin
                if (pair[p] && fus < limit) begin
                    slot_vld[used]               = 1'b1;
                    slot_fused[used]             = 1'b1;
                    slot_t0[used*TAG_W +: TAG_W] = desc[p].tag;
                    slot_t1[used*TAG_W +: TAG_W] = desc[p+1].tag;
                    used = used + 1;
                    fus  = fus + 1;
                    p    = p + 2;
                    if (two_fuse && fus == FUSE_TWO) stop = 1'b1;
                end else if (!two_fuse && used == width - 1 && cand[p]) begin
                    stop = 1'b1;
                end else begin
                    slot_vld[used]               = 1'b1;
                    slot_t0[used*TAG_W +: TAG_W] = desc[p].tag;
                    used = used + 1;
                    p    = p + 1;
                end
            end
        end
        consumed = CNT_W'(p);
        n_uops   = CNT_W'(used);
        n_fus    = 2'(fus);
    end

    // Fusion count never exceeds the one-fusion policy limit (R4)
    assert_one_fusion_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !two_fuse |-> (n_fus <= 2'd1));
    // Fusion count never exceeds two in any mode (R3)
    assert_two_fusion_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        n_fus <= 2'd2);
    // Group width in one-fusion mode stays at four slots or fewer (R5)
    assert_narrow_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !two_fuse |-> (int'(n_uops) <= WIDTH_ONE));
    // Consumption never exceeds what is visible (R7)
    assert_take_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        consumed <= avail);
endmodule

// File: rtl/fgf_out_stage.sv
// Module: output register for the group, held while the downstream queue stalls.
// Assumes load is asserted only when the register is empty or being drained.
module fgf_out_stage
    import fgf_pkg::*;
#(
    parameter int WIN   = 5,
    parameter int CNT_W = $clog2(WIN + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [WIN-1:0]       d_vld,
    input  logic [WIN-1:0]       d_fused,
    input  logic [WIN*TAG_W-1:0] d_t0,
    input  logic [WIN*TAG_W-1:0] d_t1,
    input  logic [CNT_W-1:0]     d_uops,
    input  logic [1:0]           d_fus,
    input  logic                 ready,
    output logic                 q_valid,
    output logic [WIN-1:0]       q_vld,
    output logic [WIN-1:0]       q_fused,
    output logic [WIN*TAG_W-1:0] q_t0,
    output logic [WIN*TAG_W-1:0] q_t1,
    output logic [CNT_W-1:0]     q_uops,
    output logic [1:0]           q_fus
);
    // Capture a new group when loading, clear on reset, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_vld   <= '0;
            q_fused <= '0;
            q_t0    <= '0;
            q_t1    <= '0;
            q_uops  <= '0;
            q_fus   <= '0;
        end else if (load) begin
            q_valid <= |d_vld;
            q_vld   <= d_vld;
            q_fused <= d_fused;
            q_t0    <= d_t0;
            q_t1    <= d_t1;
            q_uops  <= d_uops;
            q_fus   <= d_fus;
        end
    end

    // A stalled group stays presented and unchanged (R8)
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && !ready) |=> (q_valid && $stable(q_vld) && $stable(q_fused) &&
                                 $stable(q_t0) && $stable(q_t1) && $stable(q_uops)));
    // Uop count matches the number of valid slots (R9)
    assert_uop_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |-> ($countones(q_vld) == int'(q_uops)));
    // Fusion count matches the number of fused slots (R9)
    assert_fusion_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |-> ($countones(q_fused) == int'(q_fus)));
    // Fused flags only sit on valid slots (R1)
    assert_fused_in_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q_fused & ~q_vld) == '0);
endmodule

// File: rtl/fgf_group_former.sv
// Module: top of the macro-fusion decode group former. It unpacks the input
// window, detects fusable pairs, forms one group and registers it for a
// valid/ready consumer. Assumes the upstream queue pops in_take entries per clock.
module fgf_group_former
    import fgf_pkg::*;
#(
    parameter int WIN       = 5,
    parameter int WIDTH_ONE = 4,
    parameter int CNT_W     = $clog2(WIN + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 two_fuse_mode,
    input  logic                 post_rules,
    input  logic [WIN*DESC_W-1:0] in_desc,
    input  logic [CNT_W-1:0]     in_avail,
    output logic [CNT_W-1:0]     in_take,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [WIN-1:0]       out_slot_vld,
    output logic [WIN-1:0]       out_fused,
    output logic [WIN*TAG_W-1:0] out_tag_first,
    output logic [WIN*TAG_W-1:0] out_tag_second,
    output logic [CNT_W-1:0]     out_uops,
    output logic [1:0]           out_fusions
);
    desc_t                desc [WIN];
    logic [WIN-1:0]       cand;
    logic [WIN-1:0]       pair;
    logic [WIN-1:0]       g_vld;
    logic [WIN-1:0]       g_fused;
    logic [WIN*TAG_W-1:0] g_t0;
    logic [WIN*TAG_W-1:0] g_t1;
    logic [CNT_W-1:0]     g_consumed;
    logic [CNT_W-1:0]     g_uops;
    logic [1:0]           g_fus;
    logic                 load;

    for (genvar i = 0; i < WIN; i++) begin : g_unpack
        // Window entry i as a typed descriptor
        assign desc[i] = desc_t'(in_desc[i*DESC_W +: DESC_W]);
    end

    fgf_fuse_detect #(.WIN(WIN), .CNT_W(CNT_W)) u_detect (
        .desc       (desc),
        .avail      (in_avail),
        .post_rules (post_rules),
        .cand       (cand),
        .pair       (pair)
    );

    fgf_group_walker #(.WIN(WIN), .WIDTH_ONE(WIDTH_ONE), .CNT_W(CNT_W)) u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .desc       (desc),
        .avail      (in_avail),
        .cand       (cand),
        .pair       (pair),
        .two_fuse   (two_fuse_mode),
        .slot_vld   (g_vld),
        .slot_fused (g_fused),
        .slot_t0    (g_t0),
        .slot_t1    (g_t1),
        .consumed   (g_consumed),
        .n_uops     (g_uops),
        .n_fus      (g_fus)
    );

    // A new group may be formed when the output register is empty or draining
    assign load    = !out_valid || out_ready;
    // Report consumption only for a group that is actually captured
    assign in_take = load ? g_consumed : '0;

    fgf_out_stage #(.WIN(WIN), .CNT_W(CNT_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .d_vld   (g_vld),
        .d_fused (g_fused),
        .d_t0    (g_t0),
        .d_t1    (g_t1),
        .d_uops  (g_uops),
        .d_fus   (g_fus),
        .ready   (out_ready),
        .q_valid (out_valid),
        .q_vld   (out_slot_vld),
        .q_fused (out_fused),
        .q_t0    (out_tag_first),
        .q_t1    (out_tag_second),
        .q_uops  (out_uops),
        .q_fus   (out_fusions)
    );

    // Nothing is consumed while a group is stalled (R8)
    assert_stall_no_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> (in_take == '0));
    // Consumption stays within the window width (R7)
    assert_take_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(in_take) <= WIN);
endmodule

// File: tb/fgf_group_former_bench.sv
// Scoreboard bench: scenario tasks push descriptors and expected groups;
// a per-cycle driver/monitor feeds the window and compares accepted groups.
module fgf_group_former_bench;
    localparam int WIN = 5;
    localparam int TW  = 8;
    localparam int DW  = 12;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           two_fuse_mode = 1'b1;
    logic           post_rules = 1'b0;
    logic [WIN*DW-1:0] in_desc = '0;
    logic [2:0]     in_avail = '0;
    logic [2:0]     in_take;
    logic           out_valid;
    logic           out_ready = 1'b1;
    logic [WIN-1:0] out_slot_vld;
    logic [WIN-1:0] out_fused;
    logic [WIN*TW-1:0] out_tag_first;
    logic [WIN*TW-1:0] out_tag_second;
    logic [2:0]     out_uops;
    logic [1:0]     out_fusions;

    fgf_group_former u_fgf_group_former (
        .clk(clk), .rst_n(rst_n), .two_fuse_mode(two_fuse_mode),
        .post_rules(post_rules), .in_desc(in_desc), .in_avail(in_avail),
        .in_take(in_take), .out_valid(out_valid), .out_ready(out_ready),
        .out_slot_vld(out_slot_vld), .out_fused(out_fused),
        .out_tag_first(out_tag_first), .out_tag_second(out_tag_second),
        .out_uops(out_uops), .out_fusions(out_fusions)
    );

    always #2 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit running = 1'b0;
    bit stall_on = 1'b0;
    bit done = 1'b0;
    int base = 0;
    int nadd = 0;

    logic [DW-1:0] stim[$];
    logic [WIN-1:0] ex_vld[$];
    logic [WIN-1:0] ex_fused[$];
    logic [WIN*TW-1:0] ex_t0[$];
    logic [WIN*TW-1:0] ex_t1[$];
    logic [1:0] ex_fus[$];
    string ex_req[$];

    logic [WIN-1:0] cur_vld;
    logic [WIN-1:0] cur_fused;
    logic [WIN*TW-1:0] cur_t0;
    logic [WIN*TW-1:0] cur_t1;
    int cur_n;

    task automatic check(input bit ok, input string req, input string what);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: %s", req, what);
        end
    endtask

    // Append one descriptor; class 0 other, 1 ALU, 2 branch
    task automatic add(input int cls, input bit mem, input bit imm);
        logic [TW-1:0] t;
        t = TW'(base + nadd);
        stim.push_back({cls[1:0], mem, imm, t});
        nadd++;
    endtask

    task automatic grp_begin();
        cur_vld = '0; cur_fused = '0; cur_t0 = '0; cur_t1 = '0; cur_n = 0;
    endtask

    // Add one slot: first index a, second index b (b < 0 means unfused)
    task automatic slot(input int a, input int b);
        cur_vld[cur_n] = 1'b1;
        cur_t0[cur_n*TW +: TW] = TW'(base + a);
        if (b >= 0) begin
            cur_fused[cur_n] = 1'b1;
            cur_t1[cur_n*TW +: TW] = TW'(base + b);
        end
        cur_n++;
    endtask

    task automatic grp_end(input string req);
        ex_vld.push_back(cur_vld);
        ex_fused.push_back(cur_fused);
        ex_t0.push_back(cur_t0);
        ex_t1.push_back(cur_t1);
        ex_fus.push_back(2'($countones(cur_fused)));
        ex_req.push_back(req);
    endtask

    task automatic scn_start(input bit two, input bit post, input bit stall);
        two_fuse_mode = two;
        post_rules = post;
        stall_on = stall;
        base = base + 16;
        nadd = 0;
    endtask

    task automatic scn_wait();
        while ((stim.size() != 0 || ex_vld.size() != 0 || out_valid) && !done)
            @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    // Per-cycle driver and monitor, acting well before the next rising edge
    always @(negedge clk) begin
        if (running && !done) begin
            cyc++;
            out_ready = stall_on ? (cyc % 3 != 0) : 1'b1;
            for (int i = 0; i < WIN; i++)
                in_desc[i*DW +: DW] = (i < stim.size()) ? stim[i] : '0;
            in_avail = (stim.size() > WIN) ? 3'(WIN) : 3'(stim.size());
            #1;
            if (out_valid && out_ready) begin
                if (ex_vld.size() == 0) begin
                    check(1'b0, "R11", "unexpected group");
                end else begin
                    logic [WIN-1:0] ev, ef;
                    logic [WIN*TW-1:0] e0, e1;
                    logic [1:0] efu;
                    string rq;
                    ev = ex_vld.pop_front(); ef = ex_fused.pop_front();
                    e0 = ex_t0.pop_front(); e1 = ex_t1.pop_front();
                    efu = ex_fus.pop_front(); rq = ex_req.pop_front();
                    check(out_slot_vld == ev && out_fused == ef &&
                          out_tag_first == e0 && out_tag_second == e1 &&
                          int'(out_uops) == $countones(ev) && out_fusions == efu, rq,
                          $sformatf("vld=%b/%b fused=%b/%b t0=%h/%h t1=%h/%h uops=%0d fus=%0d/%0d",
                                    out_slot_vld, ev, out_fused, ef, out_tag_first, e0,
                                    out_tag_second, e1, out_uops, out_fusions, efu));
                    check(int'(out_uops) == $countones(ev) && out_fusions == efu, "R9",
                          $sformatf("uops=%0d exp %0d fus=%0d exp %0d",
                                    out_uops, $countones(ev), out_fusions, efu));
                end
            end
            if (out_valid && !out_ready)
                check(in_take == 3'd0, "R8",
                      $sformatf("in_take=%0d exp 0 during stall", in_take));
            check(int'(in_take) <= int'(in_avail), "R7",
                  $sformatf("in_take=%0d exp <= %0d", in_take, in_avail));
            for (int i = 0; i < WIN; i++)
                if (i < int'(in_take)) void'(stim.pop_front());
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "R7", "watchdog expired");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R10", $sformatf("out_valid=%b exp 0", out_valid));
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(out_valid == 1'b0, "R10", $sformatf("out_valid=%b exp 0 after reset", out_valid));
        running = 1'b1;

        // R3: two fusions close the group; R1 fused tag pairs
        scn_start(1'b1, 1'b0, 1'b0);
        add(1,0,0); add(2,0,0); add(1,0,0); add(2,0,0); add(1,0,0); add(2,0,0); add(0,0,0); add(0,0,0);
        grp_begin(); slot(0,1); slot(2,3); grp_end("R3");
        grp_begin(); slot(4,5); slot(6,-1); slot(7,-1); grp_end("R1");
        scn_wait();

        // R11: others and lone branches one per slot, five wide in two-fusion mode (R6)
        scn_start(1'b1, 1'b0, 1'b0);
        add(0,0,0); add(2,0,0); add(2,0,0); add(0,0,0); add(0,0,0); add(0,0,0);
        grp_begin(); slot(0,-1); slot(1,-1); slot(2,-1); slot(3,-1); slot(4,-1); grp_end("R11");
        grp_begin(); slot(5,-1); grp_end("R11");
        scn_wait();

        // R4: second pair split in one-fusion mode
        scn_start(1'b0, 1'b0, 1'b0);
        add(1,0,0); add(2,0,0); add(1,0,0); add(2,0,0); add(0,0,0); add(0,0,0);
        grp_begin(); slot(0,1); slot(2,-1); slot(3,-1); slot(4,-1); grp_end("R4");
        grp_begin(); slot(5,-1); grp_end("R4");
        scn_wait();

        // R5: fusable op on fourth slot is held back, then fuses next cycle
        scn_start(1'b0, 1'b0, 1'b0);
        add(1,0,0); add(2,0,0); add(0,0,0); add(0,0,0); add(1,0,0); add(2,0,0); add(0,0,0);
        grp_begin(); slot(0,1); slot(2,-1); slot(3,-1); grp_end("R5");
        grp_begin(); slot(4,5); slot(6,-1); grp_end("R5");
        scn_wait();

        // R5: one-fusion mode is four slots wide
        scn_start(1'b0, 1'b0, 1'b0);
        add(0,0,0); add(0,0,0); add(0,0,0); add(0,0,0); add(0,0,0);
        grp_begin(); slot(0,-1); slot(1,-1); slot(2,-1); slot(3,-1); grp_end("R5");
        grp_begin(); slot(4,-1); grp_end("R5");
        scn_wait();

        // R6: same stream in two-fusion mode, trailing op emitted unfused
        scn_start(1'b1, 1'b0, 1'b0);
        add(1,0,0); add(2,0,0); add(0,0,0); add(0,0,0); add(1,0,0); add(2,0,0); add(0,0,0);
        grp_begin(); slot(0,1); slot(2,-1); slot(3,-1); slot(4,-1); grp_end("R6");
        grp_begin(); slot(5,-1); slot(6,-1); grp_end("R6");
        scn_wait();

        // R2: first rule set, memory fuses, memory plus immediate does not
        scn_start(1'b1, 1'b0, 1'b0);
        add(1,1,0); add(2,0,0); add(1,1,1); add(2,0,0);
        grp_begin(); slot(0,1); slot(2,-1); slot(3,-1); grp_end("R2");
        scn_wait();

        // R2: second rule set, memory blocks, immediate fuses
        scn_start(1'b1, 1'b1, 1'b0);
        add(1,1,0); add(2,0,0); add(1,0,1); add(2,0,0);
        grp_begin(); slot(0,-1); slot(1,-1); slot(2,3); grp_end("R2");
        scn_wait();

        // R8: stream under downstream stalls, nothing lost or repeated
        scn_start(1'b1, 1'b0, 1'b1);
        add(1,0,0); add(2,0,0); add(1,0,0); add(2,0,0); add(1,0,0); add(2,0,0); add(0,0,0); add(0,0,0);
        grp_begin(); slot(0,1); slot(2,3); grp_end("R8");
        grp_begin(); slot(4,5); slot(6,-1); slot(7,-1); grp_end("R8");
        scn_wait();

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule